// File: doc/BRIEF.md
# APB-to-OPB Indirect Access Bridge

This block is an APB register slave that gives a processor indirect access to a slower on-chip peripheral bus. There is no window that maps peripheral addresses straight into the APB space. Software instead programs a small set of per-channel registers: a select word, a direction, a transfer size, a peripheral address and, for writes, a data word. It then writes a shared trigger register. The bridge captures the command of the selected channel and runs exactly one transaction on its peripheral-bus master port. That port carries a request, an acknowledge and an error.

When the transaction ends, the bridge records a status code and, for reads, the returned word in the channel's result registers. It also raises a per-channel completion bit in a shared interrupt status word, and the interrupt output stays high while any completion bit is set. Words travel across the bridge with their byte order reversed in both directions. A peripheral that never answers is cut off by a timeout, so the completion still arrives.

Top module: `opb_relay_bridge`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and `opb_req` is low.
- R2: Each channel's configuration registers return the full 32-bit value last written to them. Channel 0 uses select 0x10, direction 0x14, size 0x18, address 0x1C and write data 0x20. Channel 1 uses select 0x28, direction 0x2C, size 0x30, address 0x34 and write data 0x38.
- R3: An APB write to 0x04 with bit 0 set starts one transaction on a channel whose select register holds exactly 1. If both channels are selected, channel 0 is used. If neither is selected, no transaction starts. `opb_req` rises in the cycle after the trigger write and stays high until the transfer ends. While it is high, `opb_addr` carries the programmed address, `opb_size` carries bits [1:0] of the size register, and `opb_rnw` is 1 exactly when the direction register holds 1.
- R4: When a read is acknowledged without error, the channel's read-data register (0x84 for channel 0, 0x90 for channel 1) holds `opb_rdata` with its four bytes reversed. The channel's bus-status register (0x80 or 0x8C) reads 0.
- R5: During a write transaction, `opb_wdata` carries the channel's write-data register with its four bytes reversed.
- R6: Completion of a channel-0 transfer sets bit 16 of the interrupt status word at 0x48. Completion of a channel-1 transfer sets bit 17. `irq` is high while either bit is set.
- R7: An APB write to 0x40 with bit 0 set clears both completion bits. A write to 0x40 with bit 0 clear has no effect.
- R8: A trigger written while a transaction is in flight is ignored. The command on the bus does not change even if the channel registers are rewritten meanwhile.
- R9: If `opb_err` is high when the transfer ends, the bus-status register reads 1, the read-data register keeps its previous value and the completion bit is still set.
- R10: If neither acknowledge nor error arrives within 255 cycles of request, the bridge drops `opb_req`, sets bus status to 2 and sets the completion bit.
- R11: Reads of the trigger, clear and unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data (zero wait) |
| irq | output | 1 | Completion interrupt |
| opb_req | output | 1 | Peripheral-bus request, held for the transfer |
| opb_rnw | output | 1 | 1 = read, 0 = write |
| opb_size | output | 2 | Transfer size code |
| opb_addr | output | 32 | Peripheral-bus address |
| opb_wdata | output | 32 | Byte-reversed write data |
| opb_rdata | input | 32 | Peripheral-bus read data |
| opb_ack | input | 1 | Transfer acknowledge |
| opb_err | input | 1 | Transfer error |

## Verification
A sequencer stuck busy shows at once as `opb_req` staying high after an acknowledge, and as a missing completion bit two cycles later. A wrongly captured command shows on `opb_addr`, `opb_rnw` or `opb_size` in the first request cycle. A corrupted result path shows in the next APB read of the bus-status or read-data register. If the timeout counter is wrong, the request length shifts away from 255 cycles, and the bench brackets that length from both sides.

// File: rtl/opbr_pkg.sv
package opbr_pkg;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int NUM_CH  = 2;
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int IRQ_LSB = 16;

    localparam logic [ADDR_W-1:0] OFF_TRIG  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_ICLR  = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_ISTAT = 8'h48;

    typedef enum logic { SEQ_IDLE, SEQ_BUSY } seq_state_e;
    typedef enum logic [1:0] { BST_OK = 2'd0, BST_ERR = 2'd1, BST_TMO = 2'd2 } bus_stat_e;

    typedef struct packed {
        logic              rnw;
        logic [1:0]        size;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wdat;
    } opb_cmd_t;

    function automatic logic [ADDR_W-1:0] cfg_base(input int ch);
        return (ch == 0) ? 8'h10 : 8'h28;
    endfunction

    function automatic logic [ADDR_W-1:0] res_base(input int ch);
        return (ch == 0) ? 8'h80 : 8'h8C;
    endfunction

    function automatic logic [DATA_W-1:0] bswap(input logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] r;
        for (int b = 0; b < DATA_W/8; b++)
            r[8*b +: 8] = w[DATA_W-8-8*b +: 8];
        return r;
    endfunction
endpackage

// File: rtl/opbr_chan.sv
module opbr_chan
    import opbr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] CFG_BASE = 8'h10,
    parameter logic [ADDR_W-1:0] RES_BASE = 8'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              done,
    input  bus_stat_e         done_code,
    input  logic [DATA_W-1:0] done_rdata,
    input  logic              done_read,
    output logic              act,
    output opb_cmd_t          cmd,
    output logic [DATA_W-1:0] rd_val
);
    localparam logic [ADDR_W-1:0] A_SEL  = CFG_BASE;
    localparam logic [ADDR_W-1:0] A_DIR  = CFG_BASE + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_SIZE = CFG_BASE + ADDR_W'(8);
    localparam logic [ADDR_W-1:0] A_ADDR = CFG_BASE + ADDR_W'(12);
    localparam logic [ADDR_W-1:0] A_WDAT = CFG_BASE + ADDR_W'(16);
    localparam logic [ADDR_W-1:0] A_BST  = RES_BASE;
    localparam logic [ADDR_W-1:0] A_RDAT = RES_BASE + ADDR_W'(4);

    logic [DATA_W-1:0] sel_q, dir_q, size_q, addr_q, wdat_q, rdat_q;
    bus_stat_e         bst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            dir_q  <= '0;
            size_q <= '0;
            addr_q <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
            bst_q  <= BST_OK;
        end else begin
            if (wr_en) begin
                if (wr_addr == A_SEL)  sel_q  <= wr_data;
                if (wr_addr == A_DIR)  dir_q  <= wr_data;
                if (wr_addr == A_SIZE) size_q <= wr_data;
                if (wr_addr == A_ADDR) addr_q <= wr_data;
                if (wr_addr == A_WDAT) wdat_q <= wr_data;
            end
            if (done) begin
                bst_q <= done_code;
                if (done_code == BST_OK && done_read) rdat_q <= done_rdata;
            end
        end
    end

    assign act      = (sel_q == DATA_W'(1));
    assign cmd.rnw  = (dir_q == DATA_W'(1));
    assign cmd.size = size_q[1:0];
    assign cmd.addr = addr_q;
    assign cmd.wdat = wdat_q;

    always_comb begin
        rd_val = '0;
        unique case (rd_addr)
            A_SEL:   rd_val = sel_q;
            A_DIR:   rd_val = dir_q;
            A_SIZE:  rd_val = size_q;
            A_ADDR:  rd_val = addr_q;
            A_WDAT:  rd_val = wdat_q;
            A_BST:   rd_val = {{(DATA_W-2){1'b0}}, bst_q};
            A_RDAT:  rd_val = rdat_q;
            default: rd_val = '0;
        endcase
    end

    // R4: a clean read completion stores the returned word
    assert_read_store_R4: assert property (@(posedge clk) disable iff (rst)
        (done && done_code == BST_OK && done_read) |=> (rdat_q == $past(done_rdata)));
    // R9: an error completion leaves the read data untouched
    assert_err_keep_R9: assert property (@(posedge clk) disable iff (rst)
        (done && done_code != BST_OK && !wr_en) |=> $stable(rdat_q));
endmodule

// File: rtl/opbr_seq.sv
module opbr_seq
    import opbr_pkg::*;
#(
    parameter int TIMEOUT = 255
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [NUM_CH-1:0] act,
    input  opb_cmd_t          cmds [NUM_CH],
    input  logic              opb_ack,
    input  logic              opb_err,
    input  logic [DATA_W-1:0] opb_rdata,
    output logic              opb_req,
    output opb_cmd_t          cur,
    output logic              done,
    output logic [CH_W-1:0]   done_ch,
    output bus_stat_e         done_code,
    output logic [DATA_W-1:0] done_rdata
);
    localparam int CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic             pick_ok;
    logic [CH_W-1:0]  pick_ch;

    // lowest-numbered selected channel wins
    always_comb begin
        pick_ok = 1'b0;
        pick_ch = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (act[i]) begin
                pick_ok = 1'b1;
                pick_ch = CH_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_IDLE;
            cnt        <= '0;
            cur        <= '0;
            done       <= 1'b0;
            done_ch    <= '0;
            done_code  <= BST_OK;
            done_rdata <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (trig && pick_ok) begin
                        state   <= SEQ_BUSY;
                        cur     <= cmds[pick_ch];
                        done_ch <= pick_ch;
                        cnt     <= '0;
                    end
                end
                SEQ_BUSY: begin
                    if (opb_err || opb_ack) begin
                        state      <= SEQ_IDLE;
                        done       <= 1'b1;
                        done_code  <= opb_err ? BST_ERR : BST_OK;
                        done_rdata <= bswap(opb_rdata);
                    end else if (cnt == CNT_LAST) begin
                        state     <= SEQ_IDLE;
                        done      <= 1'b1;
                        done_code <= BST_TMO;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign opb_req = (state == SEQ_BUSY);

    // R3: request is held until a response or the timeout
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (opb_req && !opb_ack && !opb_err && cnt != CNT_LAST) |=> opb_req);
    // R8: the command on the bus never changes from one cycle to the next of a transfer
    assert_cmd_stable_R8: assert property (@(posedge clk) disable iff (rst)
        opb_req |=> $stable(cur));
    // R10: the wait counter stays inside the timeout window
    assert_tmo_bound_R10: assert property (@(posedge clk) disable iff (rst)
        opb_req |-> (cnt < CNT_W'(TIMEOUT)));
    // R6: a completion is a single-cycle event
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/opb_relay_bridge.sv
module opb_relay_bridge
    import opbr_pkg::*;
#(
    parameter int TIMEOUT = 255
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              irq,
    output logic              opb_req,
    output logic              opb_rnw,
    output logic [1:0]        opb_size,
    output logic [DATA_W-1:0] opb_addr,
    output logic [DATA_W-1:0] opb_wdata,
    input  logic [DATA_W-1:0] opb_rdata,
    input  logic              opb_ack,
    input  logic              opb_err
);
    logic              apb_wr, trig, iclr;
    logic [NUM_CH-1:0] act;
    opb_cmd_t          cmds   [NUM_CH];
    logic [DATA_W-1:0] rd_vals[NUM_CH];
    opb_cmd_t          cur;
    logic              done;
    logic [CH_W-1:0]   done_ch;
    bus_stat_e         done_code;
    logic [DATA_W-1:0] done_rdata;
    logic [NUM_CH-1:0] pend;

    assign apb_wr = psel && penable && pwrite;
    assign trig   = apb_wr && (paddr == OFF_TRIG) && pwdata[0];
    assign iclr   = apb_wr && (paddr == OFF_ICLR) && pwdata[0];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        opbr_chan #(
            .CFG_BASE(cfg_base(g)),
            .RES_BASE(res_base(g))
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (apb_wr),
            .wr_addr   (paddr),
            .wr_data   (pwdata),
            .rd_addr   (paddr),
            .done      (done && done_ch == CH_W'(g)),
            .done_code (done_code),
            .done_rdata(done_rdata),
            .done_read (cur.rnw),
            .act       (act[g]),
            .cmd       (cmds[g]),
            .rd_val    (rd_vals[g])
        );
    end

    opbr_seq #(.TIMEOUT(TIMEOUT)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .act       (act),
        .cmds      (cmds),
        .opb_ack   (opb_ack),
        .opb_err   (opb_err),
        .opb_rdata (opb_rdata),
        .opb_req   (opb_req),
        .cur       (cur),
        .done      (done),
        .done_ch   (done_ch),
        .done_code (done_code),
        .done_rdata(done_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else begin
            if (iclr) pend <= '0;
            if (done) pend[done_ch] <= 1'b1;
        end
    end

    always_comb begin
        prdata = (paddr == OFF_ISTAT) ? (DATA_W'(pend) << IRQ_LSB) : '0;
        for (int i = 0; i < NUM_CH; i++) prdata = prdata | rd_vals[i];
    end

    assign irq       = |pend;
    assign opb_rnw   = cur.rnw;
    assign opb_size  = cur.size;
    assign opb_addr  = cur.addr;
    assign opb_wdata = bswap(cur.wdat);

    // R6: a completion raises its channel's status bit
    assert_pend_set_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> pend[$past(done_ch)]);
    // R7: a clear with no simultaneous completion empties the status word
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (iclr && !done) |=> (pend == '0));
endmodule

// File: tb/opb_relay_bridge_test.sv
module opb_relay_bridge_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite;
    logic [7:0]  paddr;
    logic [31:0] pwdata, prdata;
    logic        irq, opb_req, opb_rnw;
    logic [1:0]  opb_size;
    logic [31:0] opb_addr, opb_wdata, opb_rdata;
    logic        opb_ack, opb_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    opb_relay_bridge uut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq),
        .opb_req(opb_req), .opb_rnw(opb_rnw), .opb_size(opb_size),
        .opb_addr(opb_addr), .opb_wdata(opb_wdata), .opb_rdata(opb_rdata),
        .opb_ack(opb_ack), .opb_err(opb_err)
    );

    typedef struct packed {
        logic        ch;
        logic [31:0] dir;
        logic [31:0] size;
        logic [31:0] addr;
        logic [31:0] wdat;
        logic [31:0] remote;
        logic [7:0]  delay;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h1, 32'h3, 32'hA000_0000, 32'h0,         32'hC002_2D15, 8'd0},
        '{1'b1, 32'h1, 32'h3, 32'hA000_0000, 32'h0,         32'hC002_2D15, 8'd3},
        '{1'b0, 32'h0, 32'h3, 32'hA000_0010, 32'h1122_3344, 32'h0,         8'd2},
        '{1'b1, 32'h1, 32'h1, 32'hA000_0400, 32'h0,         32'h89AB_CDEF, 8'd5}
    };

    function automatic logic [7:0] cbase(input logic ch);
        return ch ? 8'h28 : 8'h10;
    endfunction
    function automatic logic [7:0] rbase(input logic ch);
        return ch ? 8'h8C : 8'h80;
    endfunction
    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic respond(input logic [31:0] data, input int delay, input logic err);
        for (int i = 0; i < delay; i++) @(negedge clk);
        opb_ack = ~err; opb_err = err; opb_rdata = data;
        @(negedge clk);
        opb_ack = 1'b0; opb_err = 1'b0;
        @(negedge clk);
    endtask

    task automatic setup_ch(input logic ch, input logic [31:0] dir, input logic [31:0] size,
                            input logic [31:0] addr, input logic [31:0] wdat);
        apb_write(cbase(~ch), 32'h0);
        apb_write(cbase(ch), 32'h1);
        apb_write(cbase(ch) + 8'h04, dir);
        apb_write(cbase(ch) + 8'h08, size);
        apb_write(cbase(ch) + 8'h0C, addr);
        apb_write(cbase(ch) + 8'h10, wdat);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] exp_rd [2];
        exp_rd[0] = 32'h0;
        exp_rd[1] = 32'h0;
        psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
        opb_rdata = 0; opb_ack = 0; opb_err = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 opb_req", {31'b0, opb_req}, 32'h0);
        apb_read(8'h48, rd); chk("R1 istat", rd, 32'h0);
        apb_read(8'h10, rd); chk("R1 sel0", rd, 32'h0);
        apb_read(8'h90, rd); chk("R1 rdat1", rd, 32'h0);

        // R2 readback of full words on both channels
        for (int c = 0; c < 2; c++) begin
            for (int k = 0; k < 5; k++) begin
                logic [7:0] a;
                a = cbase(c[0]) + 8'(4 * k);
                apb_write(a, 32'hF3F4_F500 | 32'(a));
                apb_read(a, rd);
                chk("R2 readback", rd, 32'hF3F4_F500 | 32'(a));
                apb_write(a, 32'h0);
            end
        end

        // R11 unmapped, trigger and clear offsets read 0
        apb_read(8'h00, rd); chk("R11 unmapped 0x00", rd, 32'h0);
        apb_read(8'h7C, rd); chk("R11 unmapped 0x7C", rd, 32'h0);
        apb_read(8'h04, rd); chk("R11 trigger", rd, 32'h0);

        // R3 trigger with no channel selected does nothing
        apb_write(8'h04, 32'h1);
        chk("R3 no select", {31'b0, opb_req}, 32'h0);

        // table-driven transfers (R3 R4 R5 R6 R7)
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            t = VECS[v];
            setup_ch(t.ch, t.dir, t.size, t.addr, t.wdat);
            apb_write(8'h40, 32'h1);
            apb_read(8'h48, rd); chk("R7 cleared", rd, 32'h0);
            apb_write(8'h04, 32'h1);
            chk("R3 req", {31'b0, opb_req}, 32'h1);
            chk("R3 addr", opb_addr, t.addr);
            chk("R3 rnw", {31'b0, opb_rnw}, {31'b0, t.dir == 32'h1});
            chk("R3 size", {30'b0, opb_size}, {30'b0, t.size[1:0]});
            if (t.dir != 32'h1) chk("R5 wdata", opb_wdata, rev(t.wdat));
            respond(t.remote, t.delay, 1'b0);
            if (t.dir == 32'h1) exp_rd[t.ch] = rev(t.remote);
            chk("R3 req drop", {31'b0, opb_req}, 32'h0);
            chk("R6 irq", {31'b0, irq}, 32'h1);
            apb_read(8'h48, rd); chk("R6 istat", rd, t.ch ? 32'h0002_0000 : 32'h0001_0000);
            apb_read(rbase(t.ch), rd); chk("R4 bstat", rd, 32'h0);
            apb_read(rbase(t.ch) + 8'h04, rd); chk("R4 rdata", rd, exp_rd[t.ch]);
        end

        // R7 clear with bit 0 low has no effect, with bit 0 high clears
        apb_write(8'h40, 32'h0);
        apb_read(8'h48, rd); chk("R7 no-op clear", rd, 32'h0002_0000);
        apb_write(8'h40, 32'h1);
        apb_read(8'h48, rd); chk("R7 clear", rd, 32'h0);
        chk("R7 irq low", {31'b0, irq}, 32'h0);

        // R3 both selected: channel 0 wins
        apb_write(8'h28, 32'h1);
        apb_write(8'h10, 32'h1);
        apb_write(8'h1C, 32'hA000_0100);
        apb_write(8'h34, 32'hA000_0200);
        apb_write(8'h04, 32'h1);
        chk("R3 priority addr", opb_addr, 32'hA000_0100);
        respond(32'h0, 0, 1'b0);
        apb_read(8'h48, rd); chk("R3 priority istat", rd, 32'h0001_0000);
        apb_write(8'h40, 32'h1);

        // R8 trigger while busy is ignored
        setup_ch(1'b0, 32'h1, 32'h3, 32'hA000_0040, 32'h0);
        apb_write(8'h04, 32'h1);
        apb_write(8'h1C, 32'hA000_0080);
        apb_write(8'h04, 32'h1);
        chk("R8 addr kept", opb_addr, 32'hA000_0040);
        respond(32'h0102_0304, 0, 1'b0);
        exp_rd[0] = 32'h0403_0201;
        @(negedge clk);
        chk("R8 no restart", {31'b0, opb_req}, 32'h0);
        apb_read(8'h84, rd); chk("R8 rdata", rd, exp_rd[0]);
        apb_write(8'h40, 32'h1);

        // R9 error response
        apb_write(8'h04, 32'h1);
        respond(32'hDEAD_BEEF, 1, 1'b1);
        apb_read(8'h80, rd); chk("R9 bstat", rd, 32'h1);
        apb_read(8'h84, rd); chk("R9 rdata kept", rd, exp_rd[0]);
        apb_read(8'h48, rd); chk("R9 istat", rd, 32'h0001_0000);
        apb_write(8'h40, 32'h1);

        // R10 timeout after 255 request cycles
        apb_write(8'h04, 32'h1);
        repeat (250) @(negedge clk);
        chk("R10 still waiting", {31'b0, opb_req}, 32'h1);
        repeat (10) @(negedge clk);
        chk("R10 req dropped", {31'b0, opb_req}, 32'h0);
        apb_read(8'h80, rd); chk("R10 bstat", rd, 32'h2);
        apb_read(8'h48, rd); chk("R10 istat", rd, 32'h0001_0000);
        chk("R10 irq", {31'b0, irq}, 32'h1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule